// File: doc/BRIEF.md
# Floating-Point Frexp Decomposition Unit

This unit splits an IEEE-754 binary32 or binary64 value into a signed integer exponent and a fractional mantissa, in the way the C `frexp` library call does. For any finite non-zero input, the mantissa magnitude lies in [0.5, 1.0) and mantissa × 2^exponent equals the input exactly. Subnormal inputs are normalized with a leading-zero count before either result is formed. Zeros, infinities and NaNs give fixed results, and some of these results are not the usual ones.

One select input chooses the precision and another chooses which result to return. A request is a single cycle with `valid_i` high. The answer appears on `result_o`, with `valid_o` high, one clock later. The registered result is held until the next request.

Top module: `fp_frexp_unit`

## Requirements
- R1: `valid_o` is high in exactly the cycles that follow a cycle with `valid_i` high. `result_o` changes only after a cycle with `valid_i` high and otherwise keeps its value.
- R2: Exponent operation (`op_mant_i`=0) on a normal input with biased exponent field e gives e − bias + 1 (bias 127 or 1023), as a two's-complement value in `result_o[31:0]`.
- R3: Mantissa operation (`op_mant_i`=1) on a normal input keeps the sign and fraction bits and sets the biased exponent field to bias − 1, which places the magnitude in [0.5, 1.0).
- R4: A subnormal input is normalized. The exponent result is 1 − bias − lz, where lz is the count of leading zeros in the fraction field. The mantissa has exponent field bias − 1 and the fraction shifted left by lz + 1 bits, and it keeps the input sign.
- R5: A zero of either sign gives exponent result 0, and a mantissa result equal to the input zero with its sign.
- R6: An infinity or NaN input to the exponent operation gives −1 (0xFFFFFFFF in `result_o[31:0]`).
- R7: An infinity of either sign to the mantissa operation gives a negative quiet NaN: 0xFFC00000 in single precision, 0xFFF8000000000000 in double precision.
- R8: A NaN input to the mantissa operation gives a NaN with the input sign and the input payload, with the quiet bit (the fraction MSB) forced to 1.
- R9: With `dbl_i`=0 the operand is `operand_i[31:0]`. Bits 63:32 of the operand are ignored, and `result_o[63:32]` is 0. With `dbl_i`=1 all 64 bits are used.
- R10: An exponent result occupies `result_o[31:0]`, and `result_o[63:32]` is 0.
- R11: While `rst_ni` is low, `valid_o` and `result_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| dbl_i | input | 1 | 1 = binary64 operand, 0 = binary32 in bits 31:0 |
| op_mant_i | input | 1 | 1 = return the mantissa, 0 = return the exponent |
| operand_i | input | 64 | Floating-point operand |
| valid_o | output | 1 | Result strobe, one cycle after `valid_i` |
| result_o | output | 64 | Registered exponent or mantissa |

## Verification
The hardest inputs to reach are subnormals at the two extremes of the leading-zero count. When only the lowest fraction bit is set, the shift and the exponent correction are at their largest. When the fraction MSB is set, the leading one is shifted out entirely. The directed tasks apply these bit patterns directly in both precisions. The stimulus also includes a two-bit fraction, so that surviving fraction bits can be seen after the shift. Signalling NaNs and garbage in the unused upper operand bits are applied the same way. This exercises the quieting rule and the single-precision isolation rule.

// File: rtl/frexp_pkg.sv
package frexp_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_SUB,
    CLS_NORM,
    CLS_INF,
    CLS_NAN
  } fp_class_e;
endpackage

// File: rtl/fp_classify.sv
module fp_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W-1:0]        exp_i,
  input  logic [FRAC_W-1:0]       frac_i,
  output frexp_pkg::fp_class_e    cls_o
);
  import frexp_pkg::*;

  logic exp_zero, exp_ones, frac_zero;
  assign exp_zero  = (exp_i == '0);
  assign exp_ones  = (exp_i == '1);
  assign frac_zero = (frac_i == '0);

  always_comb begin
    if (exp_zero)      cls_o = frac_zero ? CLS_ZERO : CLS_SUB;
    else if (exp_ones) cls_o = frac_zero ? CLS_INF  : CLS_NAN;
    else               cls_o = CLS_NORM;
  end
endmodule

// File: rtl/lead_zero_cnt.sv
module lead_zero_cnt #(
  parameter int W = 23,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  in_i,
  output logic [CW-1:0] cnt_o
);
  // highest set bit wins
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (in_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end

  always_comb begin
    if (in_i != '0) begin
      AST_LZC_LEAD_ONE: assert (in_i[W-1-int'(cnt_o)]); // R4
    end
  end
endmodule

// File: rtl/frexp_core.sv
module frexp_core #(
  parameter int EXP_W     = 8,
  parameter int FRAC_W    = 23,
  parameter int EXP_RES_W = 32,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0]                  op_i,
  output logic [W-1:0]                  mant_o,
  output logic signed [EXP_RES_W-1:0]   exp_o
);
  import frexp_pkg::*;

  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int LZ_W     = $clog2(FRAC_W + 1);
  localparam int SUB_BASE = 1 - BIAS;

  logic              sgn;
  logic [EXP_W-1:0]  ef;
  logic [FRAC_W-1:0] fr;
  fp_class_e         cls;
  logic [LZ_W-1:0]   lz;
  logic [FRAC_W:0]   frac_sh;
  logic [EXP_W-1:0]  half_exp;

  assign sgn      = op_i[W-1];
  assign ef       = op_i[W-2 -: EXP_W];
  assign fr       = op_i[FRAC_W-1:0];
  assign half_exp = EXP_W'(BIAS - 1);
  assign frac_sh  = {fr, 1'b0} << lz;

  fp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
    .exp_i  (ef),
    .frac_i (fr),
    .cls_o  (cls)
  );

  lead_zero_cnt #(.W(FRAC_W)) u_lzc (
    .in_i  (fr),
    .cnt_o (lz)
  );

  always_comb begin
    mant_o = op_i;
    exp_o  = '0;
    unique case (cls)
      CLS_ZERO: begin
        mant_o = op_i;
        exp_o  = '0;
      end
      CLS_SUB: begin
        mant_o = {sgn, half_exp, frac_sh[FRAC_W-1:0]};
        exp_o  = EXP_RES_W'(SUB_BASE) - EXP_RES_W'(lz);
      end
      CLS_NORM: begin
        mant_o = {sgn, half_exp, fr};
        exp_o  = EXP_RES_W'(ef) - EXP_RES_W'(BIAS - 1);
      end
      CLS_INF: begin
        mant_o = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
        exp_o  = '1;
      end
      CLS_NAN: begin
        mant_o = {sgn, {EXP_W{1'b1}}, 1'b1, fr[FRAC_W-2:0]};
        exp_o  = '1;
      end
      default: begin
        mant_o = op_i;
        exp_o  = '0;
      end
    endcase
  end
endmodule

// File: rtl/fp_frexp_unit.sv
module fp_frexp_unit #(
  parameter int SP_EXP_W  = 8,
  parameter int SP_FRAC_W = 23,
  parameter int DP_EXP_W  = 11,
  parameter int DP_FRAC_W = 52,
  parameter int EXP_RES_W = 32,
  localparam int SP_W = 1 + SP_EXP_W + SP_FRAC_W,
  localparam int DP_W = 1 + DP_EXP_W + DP_FRAC_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            dbl_i,
  input  logic            op_mant_i,
  input  logic [DP_W-1:0] operand_i,
  output logic            valid_o,
  output logic [DP_W-1:0] result_o
);
  logic [SP_W-1:0]                sp_mant;
  logic signed [EXP_RES_W-1:0]    sp_exp;
  logic [DP_W-1:0]                dp_mant;
  logic signed [EXP_RES_W-1:0]    dp_exp;
  logic [DP_W-1:0]                res_d;

  frexp_core #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W), .EXP_RES_W(EXP_RES_W)) u_sp (
    .op_i   (operand_i[SP_W-1:0]),
    .mant_o (sp_mant),
    .exp_o  (sp_exp)
  );

  frexp_core #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W), .EXP_RES_W(EXP_RES_W)) u_dp (
    .op_i   (operand_i),
    .mant_o (dp_mant),
    .exp_o  (dp_exp)
  );

  always_comb begin
    unique case ({dbl_i, op_mant_i})
      2'b00:   res_d = DP_W'(unsigned'(sp_exp));
      2'b01:   res_d = DP_W'(sp_mant);
      2'b10:   res_d = DP_W'(unsigned'(dp_exp));
      default: res_d = dp_mant;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= res_d;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o))); // R1
  AST_SP_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dbl_i) |=> (result_o[DP_W-1:SP_W] == '0)); // R9
  AST_EXP_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !op_mant_i) |=> (result_o[DP_W-1:EXP_RES_W] == '0)); // R10
  AST_DP_SPECIAL_EXP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dbl_i && !op_mant_i && operand_i[DP_W-2 -: DP_EXP_W] == '1)
      |=> (result_o[EXP_RES_W-1:0] == '1)); // R6
  AST_DP_INF_MANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dbl_i && op_mant_i && operand_i[DP_W-2 -: DP_EXP_W] == '1
      && operand_i[DP_FRAC_W-1:0] == '0)
      |=> (result_o[DP_W-1] && result_o[DP_W-2 -: DP_EXP_W] == '1 && result_o[DP_FRAC_W-1])); // R7
  AST_DP_ZERO_MANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dbl_i && op_mant_i && operand_i[DP_W-2:0] == '0)
      |=> (result_o == $past(operand_i))); // R5
endmodule

// File: tb/tb_fp_frexp_unit.sv
module tb_fp_frexp_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        dbl_i = 1'b0;
  logic        op_mant_i = 1'b0;
  logic [63:0] operand_i = '0;
  logic        valid_o;
  logic [63:0] result_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fp_frexp_unit dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .dbl_i     (dbl_i),
    .op_mant_i (op_mant_i),
    .operand_i (operand_i),
    .valid_o   (valid_o),
    .result_o  (result_o)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one request at a falling edge, sample at the following falling edge
  task automatic run_op(string req, bit dbl, bit mant, logic [63:0] opnd, logic [63:0] exp);
    @(negedge clk_i);
    valid_i = 1'b1; dbl_i = dbl; op_mant_i = mant; operand_i = opnd;
    @(negedge clk_i);
    valid_i = 1'b0;
    check({req, " valid"}, 64'(valid_o), 64'd1);
    check(req, result_o, exp);
  endtask

  task automatic t_reset();
    check("R11 valid", 64'(valid_o), 64'd0);
    check("R11 result", result_o, 64'd0);
  endtask

  task automatic t_normal();
    run_op("R2 sp 1.0 exp", 0, 0, 64'h3F800000, 64'd1);
    run_op("R3 sp 1.0 mant", 0, 1, 64'h3F800000, 64'h3F000000);
    run_op("R2 sp 8.0 exp", 0, 0, 64'h41000000, 64'd4);
    run_op("R3 sp -3.0 mant", 0, 1, 64'hC0400000, 64'hBF400000);
    run_op("R2 sp max exp", 0, 0, 64'h7F7FFFFF, 64'd128);
    run_op("R3 sp max mant", 0, 1, 64'h7F7FFFFF, 64'h3F7FFFFF);
    run_op("R2 dp -2.5 exp", 1, 0, 64'hC004000000000000, 64'd2);
    run_op("R3 dp -2.5 mant", 1, 1, 64'hC004000000000000, 64'hBFE4000000000000);
    run_op("R3 dp 1.0 mant", 1, 1, 64'h3FF0000000000000, 64'h3FE0000000000000);
  endtask

  task automatic t_subnormal();
    run_op("R4 sp min exp", 0, 0, 64'h00000001, 64'h00000000FFFFFF6C);
    run_op("R4 sp min mant", 0, 1, 64'h00000001, 64'h3F000000);
    run_op("R4 sp msb exp", 0, 0, 64'h00400000, 64'h00000000FFFFFF82);
    run_op("R4 sp msb mant", 0, 1, 64'h00400000, 64'h3F000000);
    run_op("R4 sp 3 exp", 0, 0, 64'h80000003, 64'h00000000FFFFFF6D);
    run_op("R4 sp -3 mant", 0, 1, 64'h80000003, 64'hBF400000);
    run_op("R4 dp min exp", 1, 0, 64'h0000000000000001, 64'h00000000FFFFFBCF);
    run_op("R4 dp max exp", 1, 0, 64'h000FFFFFFFFFFFFF, 64'h00000000FFFFFC02);
    run_op("R4 dp max mant", 1, 1, 64'h000FFFFFFFFFFFFF, 64'h3FEFFFFFFFFFFFFE);
  endtask

  task automatic t_zero();
    run_op("R5 sp -0 exp", 0, 0, 64'h80000000, 64'd0);
    run_op("R5 sp -0 mant", 0, 1, 64'h80000000, 64'h80000000);
    run_op("R5 dp +0 mant", 1, 1, 64'h0, 64'h0);
    run_op("R5 dp -0 mant", 1, 1, 64'h8000000000000000, 64'h8000000000000000);
  endtask

  task automatic t_special();
    run_op("R6 sp inf exp", 0, 0, 64'h7F800000, 64'h00000000FFFFFFFF);
    run_op("R6 dp nan exp", 1, 0, 64'h7FF8000000000000, 64'h00000000FFFFFFFF);
    run_op("R7 sp +inf mant", 0, 1, 64'h7F800000, 64'hFFC00000);
    run_op("R7 dp -inf mant", 1, 1, 64'hFFF0000000000000, 64'hFFF8000000000000);
    run_op("R8 sp snan mant", 0, 1, 64'h7F800001, 64'h7FC00001);
    run_op("R8 dp -snan mant", 1, 1, 64'hFFF0000000000005, 64'hFFF8000000000005);
  endtask

  task automatic t_select();
    run_op("R9 sp upper ignored exp", 0, 0, 64'hDEADBEEF3F800000, 64'd1);
    run_op("R9 sp upper ignored mant", 0, 1, 64'hFFFFFFFFC0400000, 64'hBF400000);
    run_op("R10 dp exp upper zero", 1, 0, 64'h3FF0000000000000, 64'd1);
  endtask

  task automatic t_hold();
    run_op("R1 before hold", 0, 1, 64'h3F800000, 64'h3F000000);
    @(negedge clk_i);
    operand_i = 64'h41000000; op_mant_i = 1'b0;
    @(negedge clk_i);
    check("R1 idle valid", 64'(valid_o), 64'd0);
    check("R1 idle hold", result_o, 64'h3F000000);
  endtask

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_normal();
    t_subnormal();
    t_zero();
    t_special();
    t_select();
    t_hold();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule